// File: doc/BRIEF.md
# Data Byte Array Access Controller

This block gives a CPU bus access to a small nonvolatile array that holds only data. The array is modelled as a register array. The CPU reads one byte at a time through a read port with a fixed number of wait states. It rewrites the array through a command port that takes two operations: program one byte, or erase one whole 1 KB block. A control register carries the single access-enable bit. After reset that bit is clear, so software must set it before the array can be used.

Some conditions lock the array out:

- a rewrite is already running;
- the code memory is being reprogrammed, shown by the `code_pgm_active` input;
- a read is tagged as an instruction fetch.

A refused access returns zero data and pulses an error output for one cycle. While a rewrite runs, the control register holds its value, and a low-power entry request gets no grant.

Program and erase each run for a fixed, parameter-set number of cycles. A program can only clear bits, so the stored byte becomes the old byte ANDed with the written data. An erase sets every byte of the selected block to 0xFF, one byte per cycle. The upper address bits, above `BLK_W`, choose the block. `ADDR_W` must be larger than `BLK_W`, and `ERASE_CYC` must be at least 2**`BLK_W`.

Top module: `dfa_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, `busy` is low, `rd_ready` is high and every array byte holds 0xFF. Bit 0 of the control register is the enable flag, and bits 7 to 1 always read zero, whatever value is written.
- R2: An accepted read takes its request cycle plus three wait cycles. `rd_ready` is low for exactly three cycles. In the cycle after those three, `rd_valid` is high, `rd_data` carries the addressed byte and `acc_err` is low.
- R3: While the enable bit is 0, every read and every command is refused. A refused read gives `rd_valid` and `acc_err` high for one cycle with `rd_data` = 0x00. A refused command pulses `acc_err` and does not raise `busy`.
- R4: A write to the control register that arrives while `busy` is high is ignored, so `cfg_rdata` keeps its value.
- R5: While `code_pgm_active` is high, reads and commands are refused in the same way as in R3.
- R6: A read with `rd_ifetch` = 1 is refused in the same way as in R3, even when access is enabled.
- R7: A program command (`cmd_op` = 0) keeps `busy` high for exactly `PROG_CYC` cycles. Afterwards the addressed byte holds the old byte AND `cmd_wdata`.
- R8: An erase command (`cmd_op` = 1) keeps `busy` high for exactly `ERASE_CYC` cycles. Afterwards every byte of the block whose upper address bits (above bit `BLK_W`-1) match `cmd_addr` reads 0xFF, and bytes in other blocks keep their values.
- R9: A command that arrives while `busy` is high pulses `cmd_err` in the next cycle and is dropped: it leaves the array unchanged.
- R10: A read that arrives while `busy` is high is refused in the same way as in R3.
- R11: `lp_grant` equals `lp_req` while `busy` is low, and is 0 while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data (bit 0 = enable) |
| cfg_rdata | output | 8 | Control register contents |
| rd_req | input | 1 | Byte read request, sampled while `rd_ready` is high |
| rd_ifetch | input | 1 | Marks the read as an instruction fetch |
| rd_addr | input | ADDR_W | Read byte address |
| rd_ready | output | 1 | High when a new read can be accepted |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 8 | Read result (0x00 when refused) |
| cmd_valid | input | 1 | Rewrite command strobe |
| cmd_op | input | 1 | 0 = program byte, 1 = erase block |
| cmd_addr | input | ADDR_W | Command byte or block address |
| cmd_wdata | input | 8 | Program data |
| busy | output | 1 | A rewrite is running |
| acc_err | output | 1 | One-cycle pulse for a refused access |
| cmd_err | output | 1 | One-cycle pulse for a command issued while busy |
| code_pgm_active | input | 1 | Code memory self-programming in progress |
| lp_req | input | 1 | Low-power entry request |
| lp_grant | output | 1 | Low-power entry granted |

## Verification
The reads come in three kinds, and each answers a different question:

- Reads of freshly erased bytes give 0xFF. They show whether the array started out erased.
- Two programs to the same byte with overlapping bit patterns (0xA5, then 0x3C, which leaves 0x24) separate an AND-merge from a plain overwrite.
- An erase of one block, followed by reads in both blocks, shows whether block selection uses the upper address bits.

Refusals are provoked separately by each lock condition: disabled access, an instruction-fetch tag, the self-programming input and a running rewrite. This shows that each condition blocks access on its own. During a long erase the same window is used to try a second command, a control register write, a low-power request and a read. This confirms that the error, freeze and grant rules apply only while busy.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } dfa_op_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam int         RD_WAITS    = 3;
endpackage

// File: rtl/dfa_array.sv
module dfa_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // Storage starts erased; writes land one byte per cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= dfa_pkg::ERASED_BYTE;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/dfa_rewrite_seq.sv
module dfa_rewrite_seq
    import dfa_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int BLK_W     = 10,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 1040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic [7:0]        old_byte,
    output logic [ADDR_W-1:0] old_addr,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);
    localparam int LONGEST   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W     = $clog2(LONGEST + 1);
    localparam int BLK_BYTES = 1 << BLK_W;
    localparam int TAG_W     = ADDR_W - BLK_W;

    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] SWEEP_END  = CNT_W'(BLK_BYTES);

    typedef struct packed {
        logic              busy;
        dfa_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = s_q.addr;
        mem_wdata = s_q.data & old_byte;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.op   = dfa_op_e'(op_i);
                s_d.addr = addr_i;
                s_d.data = wdata_i;
                s_d.cnt  = '0;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.op == OP_PROG) begin
                // Single merged write in the final cycle of the operation.
                if (s_q.cnt == PROG_LAST) begin
                    mem_we   = 1'b1;
                    s_d.busy = 1'b0;
                end
            end else begin
                // Sweep the selected block one byte per cycle.
                if (s_q.cnt < SWEEP_END) begin
                    mem_we    = 1'b1;
                    mem_waddr = {s_q.addr[ADDR_W-1 -: TAG_W], s_q.cnt[BLK_W-1:0]};
                    mem_wdata = ERASED_BYTE;
                end
                if (s_q.cnt == ERASE_LAST) begin
                    s_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, op: OP_PROG, addr: '0, data: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign old_addr = s_q.addr;
endmodule

// File: rtl/dfa_ctrl.sv
module dfa_ctrl
    import dfa_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int BLK_W     = 10,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 1040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              rd_req,
    input  logic              rd_ifetch,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              busy,
    output logic              acc_err,
    output logic              cmd_err,
    input  logic              code_pgm_active,
    input  logic              lp_req,
    output logic              lp_grant
);
    localparam int WCNT_W = $clog2(RD_WAITS + 1);
    localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(RD_WAITS);

    typedef struct packed {
        logic              en;
        logic [WCNT_W-1:0] wcnt;
        logic [ADDR_W-1:0] raddr;
        logic              valid;
        logic [7:0]        data;
        logic              aerr;
        logic              cerr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              seq_busy;
    logic              seq_start;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_byte;
    logic [ADDR_W-1:0] old_addr;
    logic [7:0]        old_byte;
    logic              locked;
    logic              rd_refuse;

    assign locked    = !c_q.en || code_pgm_active;
    assign rd_refuse = locked || rd_ifetch || seq_busy;
    assign seq_start = cmd_valid && !seq_busy && !locked;

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        c_d.data  = 8'h00;
        c_d.aerr  = 1'b0;
        c_d.cerr  = 1'b0;

        // Control register: frozen while a rewrite runs.
        if (cfg_we && !seq_busy) begin
            c_d.en = cfg_wdata[0];
        end

        // Read path: one access cycle plus fixed wait states.
        if (c_q.wcnt != '0) begin
            if (c_q.wcnt == WAIT_LAST) begin
                c_d.wcnt  = '0;
                c_d.valid = 1'b1;
                c_d.data  = rd_byte;
            end else begin
                c_d.wcnt = c_q.wcnt + 1'b1;
            end
        end else if (rd_req) begin
            if (rd_refuse) begin
                c_d.valid = 1'b1;
                c_d.aerr  = 1'b1;
            end else begin
                c_d.wcnt  = WCNT_W'(1);
                c_d.raddr = rd_addr;
            end
        end

        // Command path.
        if (cmd_valid) begin
            if (seq_busy) begin
                c_d.cerr = 1'b1;
            end else if (locked) begin
                c_d.aerr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    dfa_rewrite_seq #(
        .ADDR_W   (ADDR_W),
        .BLK_W    (BLK_W),
        .PROG_CYC (PROG_CYC),
        .ERASE_CYC(ERASE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .op_i     (cmd_op),
        .addr_i   (cmd_addr),
        .wdata_i  (cmd_wdata),
        .old_byte (old_byte),
        .old_addr (old_addr),
        .busy     (seq_busy),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    dfa_array #(
        .ADDR_W(ADDR_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr_a(c_q.raddr),
        .rdata_a(rd_byte),
        .raddr_b(old_addr),
        .rdata_b(old_byte)
    );

    assign cfg_rdata = {7'b0, c_q.en};
    assign rd_ready  = (c_q.wcnt == '0);
    assign rd_valid  = c_q.valid;
    assign rd_data   = c_q.data;
    assign acc_err   = c_q.aerr;
    assign cmd_err   = c_q.cerr;
    assign busy      = seq_busy;
    assign lp_grant  = lp_req && !seq_busy;
endmodule

// File: rtl/dfa_ctrl_chk.sv
module dfa_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_rdata,
    input logic       rd_req,
    input logic       rd_ifetch,
    input logic       rd_ready,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       cmd_valid,
    input logic       busy,
    input logic       acc_err,
    input logic       cmd_err,
    input logic       code_pgm_active,
    input logic       lp_req,
    input logic       lp_grant
);
    AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_ready) |=> !rd_ready ##1 !rd_ready ##1 (rd_ready && rd_valid && !acc_err)); // R2

    AST_DISABLED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cfg_rdata[0] && !busy) |=> (!busy && acc_err)); // R3

    AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && acc_err) |-> (rd_data == 8'h00)); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && busy) |=> $stable(cfg_rdata)); // R4

    AST_SELFPROG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && code_pgm_active && !busy) |=> !busy); // R5

    AST_IFETCH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready && rd_ifetch) |=> (rd_valid && acc_err)); // R6

    AST_BUSY_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_err); // R9

    AST_BUSY_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready && busy) |=> (rd_valid && acc_err)); // R10

    AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lp_grant); // R11

    AST_LP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_req && !busy) |-> lp_grant); // R11
endmodule

bind dfa_ctrl dfa_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_rdata      (cfg_rdata),
    .rd_req         (rd_req),
    .rd_ifetch      (rd_ifetch),
    .rd_ready       (rd_ready),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .cmd_valid      (cmd_valid),
    .busy           (busy),
    .acc_err        (acc_err),
    .cmd_err        (cmd_err),
    .code_pgm_active(code_pgm_active),
    .lp_req         (lp_req),
    .lp_grant       (lp_grant)
);

// File: tb/sim_dfa_ctrl.sv
module sim_dfa_ctrl;
    localparam int ADDR_W    = 11;
    localparam int BLK_W     = 10;
    localparam int PROG_CYC  = 6;
    localparam int ERASE_CYC = 1040;
    localparam int DEPTH     = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic              rd_req = 1'b0;
    logic              rd_ifetch = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic              cmd_valid = 1'b0;
    logic              cmd_op = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_wdata = '0;
    logic              busy;
    logic              acc_err;
    logic              cmd_err;
    logic              code_pgm_active = 1'b0;
    logic              lp_req = 1'b0;
    logic              lp_grant;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 0;

    logic [7:0] model [DEPTH];
    logic [7:0] q_data [$];
    logic       q_err  [$];
    string      q_tag  [$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dfa_ctrl #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rd_req(rd_req), .rd_ifetch(rd_ifetch),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .acc_err(acc_err), .cmd_err(cmd_err), .code_pgm_active(code_pgm_active),
        .lp_req(lp_req), .lp_grant(lp_grant)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops expected read results as the design returns them.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_data.size() == 0) begin
                check(0, "R2 unexpected read result", rd_data, 0);
            end else begin
                logic [7:0] ed;
                logic       ee;
                string      tg;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                tg = q_tag.pop_front();
                check(rd_data == ed, {tg, " data"}, rd_data, ed);
                check(acc_err == ee, {tg, " error flag"}, acc_err, ee);
            end
        end
    end

    // Driver: read one byte; refused reads expect 0x00 with the error flag.
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic f,
                           input logic refuse, input string tag);
        q_data.push_back(refuse ? 8'h00 : model[a]);
        q_err.push_back(refuse);
        q_tag.push_back(tag);
        @(negedge clk);
        rd_req    = 1'b1;
        rd_addr   = a;
        rd_ifetch = f;
        @(negedge clk);
        rd_req    = 1'b0;
        rd_ifetch = 1'b0;
        if (!refuse) begin
            int w = 0;
            while (!rd_ready) begin
                w++;
                @(negedge clk);
            end
            check(w == 3, "R2 wait cycles", w, 3);
        end else begin
            @(negedge clk);
        end
    endtask

    task automatic issue_cmd(input logic op, input logic [ADDR_W-1:0] a,
                             input logic [7:0] d, output logic aerr,
                             output logic cerr, output logic bsy);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        aerr = acc_err;
        cerr = cmd_err;
        bsy  = busy;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        check(0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        logic aerr, cerr, bsy;
        int   n, t0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cfg_rdata == 8'h00, "R1 control register after reset", cfg_rdata, 8'h00);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(rd_ready == 1'b1, "R1 ready after reset", rd_ready, 1);
        lp_req = 1'b1;
        #1;
        check(lp_grant == 1'b1, "R11 grant while idle", lp_grant, 1);
        lp_req = 1'b0;

        // R3 disabled access
        do_read(11'h005, 1'b0, 1'b1, "R3 read while disabled");
        issue_cmd(1'b0, 11'h005, 8'h00, aerr, cerr, bsy);
        check(aerr == 1'b1, "R3 command refused flag", aerr, 1);
        check(bsy == 1'b0, "R3 command no busy", bsy, 0);

        // R1 enable, upper bits read zero
        cfg_write(8'hFF);
        check(cfg_rdata == 8'h01, "R1 upper bits read zero", cfg_rdata, 8'h01);

        // R1/R2 erased content
        do_read(11'h005, 1'b0, 1'b0, "R1 erased byte");

        // R7 programming merges by AND
        issue_cmd(1'b0, 11'h005, 8'hA5, aerr, cerr, bsy);
        wait_idle(n);
        check(n == PROG_CYC, "R7 program busy cycles", n, PROG_CYC);
        model[11'h005] = model[11'h005] & 8'hA5;
        do_read(11'h005, 1'b0, 1'b0, "R7 first program");
        issue_cmd(1'b0, 11'h005, 8'h3C, aerr, cerr, bsy);
        wait_idle(n);
        model[11'h005] = model[11'h005] & 8'h3C;
        check(model[11'h005] == 8'h24, "R7 model sanity", model[11'h005], 8'h24);
        do_read(11'h005, 1'b0, 1'b0, "R7 second program AND");

        issue_cmd(1'b0, 11'h407, 8'h0F, aerr, cerr, bsy);
        wait_idle(n);
        model[11'h407] = 8'h0F;

        // R8 erase of block 0, with probes inside the busy window
        issue_cmd(1'b1, 11'h123, 8'h00, aerr, cerr, bsy);
        t0 = cyc;
        check(bsy == 1'b1, "R8 erase starts busy", bsy, 1);
        issue_cmd(1'b0, 11'h407, 8'h00, aerr, cerr, bsy);
        check(cerr == 1'b1, "R9 command while busy", cerr, 1);
        cfg_write(8'h00);
        check(cfg_rdata == 8'h01, "R4 control write ignored while busy", cfg_rdata, 8'h01);
        @(negedge clk);
        lp_req = 1'b1;
        @(negedge clk);
        check(lp_grant == 1'b0, "R11 grant held off while busy", lp_grant, 0);
        lp_req = 1'b0;
        do_read(11'h407, 1'b0, 1'b1, "R10 read while busy");
        while (busy) @(negedge clk);
        check((cyc - t0) == ERASE_CYC, "R8 erase busy cycles", cyc - t0, ERASE_CYC);
        for (int i = 0; i < (1 << BLK_W); i++) model[i] = 8'hFF;
        do_read(11'h005, 1'b0, 1'b0, "R8 erased byte in block");
        do_read(11'h3FF, 1'b0, 1'b0, "R8 last byte of block");
        do_read(11'h407, 1'b0, 1'b0, "R8 R9 other block untouched");
        lp_req = 1'b1;
        #1;
        check(lp_grant == 1'b1, "R11 grant after rewrite", lp_grant, 1);
        lp_req = 1'b0;

        // R6 instruction fetch
        do_read(11'h407, 1'b1, 1'b1, "R6 fetch refused");

        // R5 self-programming lockout
        code_pgm_active = 1'b1;
        do_read(11'h407, 1'b0, 1'b1, "R5 read during self-programming");
        issue_cmd(1'b1, 11'h400, 8'h00, aerr, cerr, bsy);
        check(aerr == 1'b1, "R5 command refused flag", aerr, 1);
        check(bsy == 1'b0, "R5 command no busy", bsy, 0);
        code_pgm_active = 1'b0;
        do_read(11'h407, 1'b0, 1'b0, "R5 access restored");

        repeat (3) @(negedge clk);
        check(q_data.size() == 0, "R2 all reads answered", q_data.size(), 0);
        finish_run();
    end
endmodule